// File: doc/BRIEF.md
# 4x4 Integer Forward Transform Engine

This block turns a 4x4 tile of signed 16-bit residual samples into sixteen transform coefficients using a separable integer butterfly. The tile arrives one row per beat on a valid/ready stream, with four 16-bit lanes per beat. Each row goes through the first (horizontal) butterfly as it is accepted, and the result is written into a small intermediate tile. Once four rows are held, a second (vertical) butterfly runs down every column of that tile. The coefficients leave one row per beat on an output valid/ready stream.

Back-pressure rules: an input row is taken on any clock edge where `src_valid` and `src_ready` are both high. `src_ready` stays low from the edge that takes the fourth row until the edge that hands over the fourth coefficient row. A row offered during that time is not taken and has no effect. `dst_valid` and `dst_data` stay fixed until `dst_ready` is seen high.

Lane j of a beat occupies bits [16j+15:16j]. Lane j of an input beat is the sample in column j. Lane j of an output beat is the coefficient for horizontal frequency j.

Top module: `fdct4_core`

## Requirements
- R1: While the synchronous active-high reset is held and in the cycle after it is released, `src_ready` is 1 and `dst_valid` is 0.
- R2: After four rows have been accepted, `src_ready` is 0 and `dst_valid` is 1 until the fourth output beat is accepted. `src_ready` returns to 1 in the next cycle. A row offered while `src_ready` is 0 is not taken.
- R3: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid` and `dst_data` hold their values into the next cycle.
- R4: Output beats appear as coefficient row 0, 1, 2, 3. Output lane j holds the column-j coefficient of that row. Input lane j is the sample in column j of the current row.
- R5: For each row, the horizontal pass computes a=(x0+x3)*8, b=(x1+x2)*8, c=(x1-x2)*8 and d=(x0-x3)*8, each wrapped to 16 bits. It then forms y0=a+b and y2=a-b, both wrapped to 16 bits.
- R6: The horizontal pass gives y1=sat16((c*2217+d*5352+14500)>>>12) and y3=sat16((d*2217-c*5352+7500)>>>12). Both are computed at 32-bit precision, and sat16 clamps the result to the range -32768..32767.
- R7: For each column of the intermediate tile, the vertical pass computes a=x0+x3, b=x1+x2, c=x1-x2 and d=x0-x3, wrapped to 16 bits and with no scaling. It then forms z0=((a+b+7) wrapped to 16)>>>4 and z2=((a-b+7) wrapped to 16)>>>4.
- R8: z1 = sat16((c*2217+d*5352+12000)>>>16), plus 1 when the vertical d is nonzero, with the sum wrapped to 16 bits.
- R9: z3 = sat16((d*2217-c*5352+51000)>>>16).
- R10: When samples are large enough that a 16-bit butterfly sum or product overflows, the result wraps modulo 2^16 and is not clamped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 1 | Input row offered |
| src_ready | output | 1 | Engine can take an input row |
| src_data | input | 64 | Input row, four signed 16-bit lanes |
| dst_valid | output | 1 | Coefficient row available |
| dst_ready | input | 1 | Downstream takes the coefficient row |
| dst_data | output | 64 | Coefficient row, four signed 16-bit lanes |

## Verification
The handshake assertions assume that reset is held for at least one rising edge before normal use. They put no constraint on `src_valid` or `dst_ready`, which may toggle freely, and on the input data, which may change while not ready. The stimulus drives `dst_ready` from a pseudo-random sequence in three modes (always ready, coin-flip, mostly stalled). It keeps `src_valid` high with the next tile's first row while the engine is draining, so the rule that un-taken rows are ignored comes up on every back-to-back tile. Sample values range over the full signed 16-bit span, so the clamp and wrap paths of the butterflies are reached.

// File: rtl/fdct4_pkg.sv
package fdct4_pkg;
  parameter int LANE_W = 16;
  parameter int LANES  = 4;
  localparam int ROW_W   = LANE_W * LANES;
  localparam int IDX_W   = $clog2(LANES);
  localparam int PROD_W  = 2 * LANE_W;

  // butterfly multipliers and rounding constants
  localparam int K_LO      = 2217;
  localparam int K_HI      = 5352;
  localparam int H_PRE     = 3;
  localparam int H_SHIFT   = 12;
  localparam int H_RND_1   = 14500;
  localparam int H_RND_3   = 7500;
  localparam int V_SHIFT   = 16;
  localparam int V_RND_1   = 12000;
  localparam int V_RND_3   = 51000;
  localparam int E_SHIFT   = 4;
  localparam int E_RND     = 7;

  typedef logic signed [LANE_W-1:0] coef_t;
  typedef coef_t [LANES-1:0] row_t;

  function automatic coef_t sat_lane(input logic signed [PROD_W-1:0] v);
    if (v > PROD_W'((1 << (LANE_W-1)) - 1))
      return {1'b0, {(LANE_W-1){1'b1}}};
    else if (v < -PROD_W'(1 << (LANE_W-1)))
      return {1'b1, {(LANE_W-1){1'b0}}};
    else
      return v[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/fdct4_hpass.sv
module fdct4_hpass
  import fdct4_pkg::*;
(
  input  row_t x,
  output row_t y
);
  coef_t s03, s12, d12, d03;
  coef_t a, b, c, d;
  logic signed [PROD_W-1:0] odd1, odd3;

  always_comb begin
    s03 = x[0] + x[3];
    s12 = x[1] + x[2];
    d12 = x[1] - x[2];
    d03 = x[0] - x[3];
    a = s03 <<< H_PRE;
    b = s12 <<< H_PRE;
    c = d12 <<< H_PRE;
    d = d03 <<< H_PRE;
    odd1 = PROD_W'(c) * PROD_W'(K_LO) + PROD_W'(d) * PROD_W'(K_HI) + PROD_W'(H_RND_1);
    odd3 = PROD_W'(d) * PROD_W'(K_LO) - PROD_W'(c) * PROD_W'(K_HI) + PROD_W'(H_RND_3);
    y[0] = a + b;
    y[2] = a - b;
    y[1] = sat_lane(odd1 >>> H_SHIFT);
    y[3] = sat_lane(odd3 >>> H_SHIFT);
  end
endmodule

// File: rtl/fdct4_vpass.sv
module fdct4_vpass
  import fdct4_pkg::*;
(
  input  row_t x,
  output row_t z
);
  coef_t a, b, c, d, e0, e2, nz;
  logic signed [PROD_W-1:0] odd1, odd3;

  always_comb begin
    a = x[0] + x[3];
    b = x[1] + x[2];
    c = x[1] - x[2];
    d = x[0] - x[3];
    e0 = a + b + coef_t'(E_RND);
    e2 = a - b + coef_t'(E_RND);
    nz = {{(LANE_W-1){1'b0}}, d != '0};
    odd1 = PROD_W'(c) * PROD_W'(K_LO) + PROD_W'(d) * PROD_W'(K_HI) + PROD_W'(V_RND_1);
    odd3 = PROD_W'(d) * PROD_W'(K_LO) - PROD_W'(c) * PROD_W'(K_HI) + PROD_W'(V_RND_3);
    z[0] = e0 >>> E_SHIFT;
    z[2] = e2 >>> E_SHIFT;
    z[1] = sat_lane(odd1 >>> V_SHIFT) + nz;
    z[3] = sat_lane(odd3 >>> V_SHIFT);
  end
endmodule

// File: rtl/fdct4_seq.sv
module fdct4_seq
  import fdct4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             src_valid,
  input  logic             dst_ready,
  output logic             src_ready,
  output logic             dst_valid,
  output logic             wr_en,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);
  logic draining;

  assign src_ready = !draining;
  assign dst_valid = draining;
  assign wr_en     = src_valid && !draining;

  always_ff @(posedge clk) begin
    if (rst) begin
      draining <= 1'b0;
      idx      <= '0;
    end else if (!draining && src_valid) begin
      idx <= idx + 1'b1;
      if (idx == LAST) draining <= 1'b1;
    end else if (draining && dst_ready) begin
      idx <= idx + 1'b1;
      if (idx == LAST) draining <= 1'b0;
    end
  end

  // R2: the fourth accepted row starts the drain
  a_r2_fill_done: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready && idx == LAST) |=> (dst_valid && !src_ready));
  // R2: earlier rows keep the engine filling
  a_r2_fill_more: assert property (@(posedge clk) disable iff (rst)
    (src_valid && src_ready && idx != LAST) |=> (src_ready && !dst_valid));
  // R2: the last handed-over row reopens the input
  a_r2_drain_done: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && dst_ready && idx == LAST) |=> (src_ready && !dst_valid));
  // R3: a stalled output keeps its place
  a_r3_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !dst_ready) |=> (dst_valid && $stable(idx)));
endmodule

// File: rtl/fdct4_core.sv
module fdct4_core
  import fdct4_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             src_valid,
  output logic             src_ready,
  input  logic [ROW_W-1:0] src_data,
  output logic             dst_valid,
  input  logic             dst_ready,
  output logic [ROW_W-1:0] dst_data
);
  logic             wr_en;
  logic [IDX_W-1:0] idx;
  row_t             h_out;
  row_t             mid_q [LANES];
  row_t             beat;

  fdct4_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .src_valid(src_valid),
    .dst_ready(dst_ready),
    .src_ready(src_ready),
    .dst_valid(dst_valid),
    .wr_en    (wr_en),
    .idx      (idx)
  );

  fdct4_hpass u_hpass (
    .x(row_t'(src_data)),
    .y(h_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < LANES; r++) mid_q[r] <= '0;
    end else if (wr_en) begin
      mid_q[idx] <= h_out;
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_col
    row_t col_in;
    row_t col_out;
    always_comb begin
      for (int i = 0; i < LANES; i++) col_in[i] = mid_q[i][j];
    end
    fdct4_vpass u_vpass (
      .x(col_in),
      .z(col_out)
    );
    assign beat[j] = col_out[idx];
  end

  assign dst_data = beat;

  // R3: stalled coefficient row stays put
  a_r3_data_hold: assert property (@(posedge clk) disable iff (rst)
    (dst_valid && !dst_ready) |=> $stable(dst_data));
endmodule

// File: tb/fdct4_core_test.sv
`timescale 1ns/1ps
module fdct4_core_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_valid = 1'b0;
  logic dst_ready = 1'b0;
  logic [63:0] src_data = '0;
  logic src_ready, dst_valid;
  logic [63:0] dst_data;

  always #4 clk = ~clk;

  fdct4_core uut (
    .clk(clk), .rst(rst),
    .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
    .dst_valid(dst_valid), .dst_ready(dst_ready), .dst_data(dst_data)
  );

  int n_run = 0;
  int n_bad = 0;
  logic [63:0] exp_q[$];
  string tag_q[$];
  bit started = 0;
  int ready_mode = 0;
  logic [31:0] lfsr = 32'hACE1_2345;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int w16(input int v);
    logic [15:0] t;
    t = v[15:0];
    return int'($signed(t));
  endfunction

  function automatic int c16(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic logic [63:0] pack4(input int l0, input int l1, input int l2, input int l3);
    return {l3[15:0], l2[15:0], l1[15:0], l0[15:0]};
  endfunction

  // expected coefficients, computed from the requirement formulas
  task automatic ref_tile(input int t[16], output logic [63:0] rows[4]);
    int m[16];
    int o[16];
    for (int r = 0; r < 4; r++) begin
      int a, b, c, d;
      a = w16((t[r*4] + t[r*4+3]) * 8);
      b = w16((t[r*4+1] + t[r*4+2]) * 8);
      c = w16((t[r*4+1] - t[r*4+2]) * 8);
      d = w16((t[r*4] - t[r*4+3]) * 8);
      m[r*4]   = w16(a + b);
      m[r*4+2] = w16(a - b);
      m[r*4+1] = c16((c * 2217 + d * 5352 + 14500) >>> 12);
      m[r*4+3] = c16((d * 2217 - c * 5352 + 7500) >>> 12);
    end
    for (int j = 0; j < 4; j++) begin
      int a, b, c, d;
      a = w16(m[j] + m[12+j]);
      b = w16(m[4+j] + m[8+j]);
      c = w16(m[4+j] - m[8+j]);
      d = w16(m[j] - m[12+j]);
      o[j]    = w16(a + b + 7) >>> 4;
      o[8+j]  = w16(a - b + 7) >>> 4;
      o[4+j]  = w16(c16((c * 2217 + d * 5352 + 12000) >>> 16) + ((d != 0) ? 1 : 0));
      o[12+j] = c16((d * 2217 - c * 5352 + 51000) >>> 16);
    end
    for (int k = 0; k < 4; k++) rows[k] = pack4(o[k*4], o[k*4+1], o[k*4+2], o[k*4+3]);
  endtask

  // driver: queue expectations, then present rows
  task automatic send_tile(input int t[16], input string tag, input int gap);
    logic [63:0] rows[4];
    ref_tile(t, rows);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(rows[k]);
      tag_q.push_back($sformatf("%s row%0d", tag, k));
    end
    for (int r = 0; r < 4; r++) begin
      if (gap > 0) begin
        @(negedge clk);
        src_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
      @(negedge clk);
      src_valid = 1'b1;
      src_data  = pack4(t[r*4], t[r*4+1], t[r*4+2], t[r*4+3]);
      while (!src_ready) @(negedge clk);
      @(posedge clk);
    end
  endtask

  // output back-pressure pattern
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (ready_mode)
        0: dst_ready = 1'b1;
        1: dst_ready = lfsr[3];
        default: dst_ready = (lfsr[2:0] == 3'd0);
      endcase
    end
  end

  // monitor / scoreboard
  initial begin
    bit stalled = 0;
    logic [63:0] stall_data = '0;
    wait (started);
    forever begin
      @(negedge clk);
      #2;
      if (stalled)
        check(dst_valid && dst_data == stall_data, "R3 held beat", dst_data, stall_data);
      stalled = dst_valid && !dst_ready;
      stall_data = dst_data;
      if (dst_valid)
        check(!src_ready, "R2 ready low while draining", 64'(src_ready), 64'd0);
      if (dst_valid && dst_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected beat", dst_data, 64'd0);
        end else begin
          logic [63:0] e;
          string tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          check(dst_data == e, tg, dst_data, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R2 watchdog expired", 64'(exp_q.size()), 64'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    int t[16];
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(src_ready == 1'b1 && dst_valid == 1'b0, "R1 during reset", {62'd0, src_ready, dst_valid}, 64'h2);
    rst = 1'b0;
    @(negedge clk);
    check(src_ready == 1'b1 && dst_valid == 1'b0, "R1 after reset", {62'd0, src_ready, dst_valid}, 64'h2);
    started = 1;

    for (int i = 0; i < 16; i++) t[i] = 0;
    send_tile(t, "R4 R5 R7 zero tile", 0);

    for (int i = 0; i < 16; i++) t[i] = 100;
    send_tile(t, "R5 R7 flat tile", 1);

    for (int i = 0; i < 16; i++) t[i] = 0;
    t[0] = 64;
    send_tile(t, "R8 R9 impulse", 0);

    for (int r = 0; r < 4; r++) begin
      t[r*4] = 12; t[r*4+1] = -40; t[r*4+2] = 7; t[r*4+3] = 90;
    end
    send_tile(t, "R8 equal rows no bump", 2);

    for (int i = 0; i < 16; i++) t[i] = i * 37 - 300;
    send_tile(t, "R4 R6 ramp", 0);

    ready_mode = 1;
    for (int r = 0; r < 4; r++) begin
      t[r*4] = 2047; t[r*4+1] = 2047; t[r*4+2] = -2048; t[r*4+3] = -2048;
    end
    send_tile(t, "R6 clamp", 0);

    for (int i = 0; i < 16; i++) t[i] = 32767;
    send_tile(t, "R10 wrap high", 0);

    for (int i = 0; i < 16; i++) t[i] = (i % 2 == 0) ? -32768 : 32767;
    send_tile(t, "R10 wrap alternating", 1);

    ready_mode = 2;
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 16; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        t[i] = (n < 3) ? (int'(lfsr[9:0]) - 512) : int'($signed(lfsr[15:0]));
      end
      send_tile(t, $sformatf("R2 R4 R6 R8 R9 random %0d", n), n % 2);
      if (n == 2) ready_mode = 1;
    end

    @(negedge clk);
    src_valid = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(src_ready == 1'b1 && dst_valid == 1'b0, "R2 idle after drain", {62'd0, src_ready, dst_valid}, 64'h2);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule